// File: doc/BRIEF.md
# Prescaled Per-Pin Input Debouncer

This block cleans up a bank of slow, noisy input lines before they reach edge or level detection. One programmable divider, shared by all lines, turns the bus clock into a sampling tick. A line whose filter is switched on takes a new level only after it has seen that level at two ticks in a row. Shorter pulses are dropped. A line whose filter is switched off passes its raw value straight to the output with no added delay.

Software sets the block up through two word registers on a simple register bus. The filter-select register holds one bit per line and sits at offset 0x40. The divider register holds a 24-bit divisor and sits at offset 0x44. The inputs are assumed to be synchronised to the bus clock already. The outputs feed the interrupt-detection logic of the pin bank. Pad control and the detection logic itself are outside this block.

Top module: `pin_debounce_filter`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0. Every output then equals its raw input.
- R2: Offset 0x40 is the filter-select register. Bit i switches filtering on for line i, with one bit per line. It reads back exactly what was written.
- R3: Offset 0x44 is the divider register. Bits 23:0 are writable and read back. Bits 31:24 read 0 and ignore writes.
- R4: With divisor P ≥ 1, a tick occurs every P clock cycles. Writing the divider register sets the count to zero, so the first tick samples at the P-th rising edge after the write edge. A filtered line whose raw input changes at the write edge shows the new level right after edge 2P.
- R5: A line whose select bit is 0 drives its output from its raw input combinationally. The output follows the raw input in the same cycle.
- R6: A filtered line changes its output only at a tick, and only after it has sampled the new level at two consecutive ticks. A level seen at one tick only is discarded.
- R7: A divisor of 0 produces no ticks. Filtered lines then hold their output whatever the raw inputs do.
- R8: A write to the divider register restarts the count from zero, wherever the count stood.
- R9: A read from any offset other than 0x40 or 0x44 returns 0. A write to such an offset changes neither register.
- R10: While a line's filter is switched off, its filtered state follows the raw input. Switching the filter on therefore shows the current raw level at once, with no glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_sel is high |
| pin_raw | input | 32 | Synchronised raw input lines |
| pin_out | output | 32 | Filtered or passed-through lines |

## Verification
The hardest case to reach is the exact tick phase when a raw level changes. A tick left over from an earlier divisor can sample the new level early and hide an error in the latency or the restart behaviour. The bench therefore parks the divider at 0, so no ticks occur. It then changes the raw lines at the very edge that loads a new divisor, which fixes tick phase zero at a known edge. From that edge it counts cycles for several divisors, pin masks and pre-write delays. The glitch and restart cases are built on the same anchor: in the glitch case the raw level is pulled back just after the first tick, and in the restart case the divisor is rewritten mid-count.

// File: rtl/dbf_pkg.sv
// Package: shared sizes and register offsets for the debouncer.
// Assumes byte-addressed word registers on an 8-bit offset bus.
package dbf_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 24;
    localparam int NPIN     = 32;

    localparam logic [ADDR_W-1:0] OFF_SELECT  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_DIVIDER = 8'h44;

    // Decoded register access for one cycle.
    typedef struct packed {
        logic sel_wr;
        logic div_wr;
    } dbf_wr_t;
endpackage

// File: rtl/dbf_regs.sv
// Module: register file for the filter-select and divider registers.
// Assumes a single-cycle write strobe; reads are combinational and
// return 0 for unmapped offsets or when bus_sel is low.
module dbf_regs
    import dbf_pkg::*;
#(
    parameter int NP = NPIN,
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NP-1:0]     sel_q,
    output logic [DW-1:0]     div_q,
    output logic              div_restart
);
    dbf_wr_t wr;

    // Decode write strobes per register.
    always_comb begin
        wr.sel_wr = bus_sel && bus_wr && (bus_addr == OFF_SELECT);
        wr.div_wr = bus_sel && bus_wr && (bus_addr == OFF_DIVIDER);
    end

    assign div_restart = wr.div_wr;

    // Hold the filter-select bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_q <= '0;
        else if (wr.sel_wr) sel_q <= bus_wdata[NP-1:0];
    end

    // Hold the divisor; upper bus bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (wr.div_wr) div_q <= bus_wdata[DW-1:0];
    end

    // Return the addressed register, zero-extended.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == OFF_SELECT)       bus_rdata[NP-1:0] = sel_q;
            else if (bus_addr == OFF_DIVIDER) bus_rdata[DW-1:0] = div_q;
        end
    end
endmodule

// File: rtl/dbf_prescaler.sv
// Module: shared tick divider. Asserts tick for one cycle every div
// cycles; div = 0 stops ticks. A restart pulse zeroes the count.
module dbf_prescaler #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    input  logic          restart,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    // Tick when the count reaches the last cycle of a period.
    assign tick = (div != '0) && (cnt_q == div - DW'(1));

    // Advance, wrap or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (restart || div == '0) cnt_q <= '0;
        else if (tick)                 cnt_q <= '0;
        else                           cnt_q <= cnt_q + DW'(1);
    end
endmodule

// File: rtl/dbf_pin_filter.sv
// Module: one-line two-sample debounce filter. Assumes raw is already
// synchronised. When disabled the state tracks raw and the output is raw.
module dbf_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic raw,
    output logic out
);
    logic filt_q;
    logic pend_q;

    // Update filtered level after two consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!enable) begin
            filt_q <= raw;
            pend_q <= 1'b0;
        end else if (tick) begin
            if (raw == filt_q) begin
                pend_q <= 1'b0;
            end else if (pend_q) begin
                filt_q <= raw;
                pend_q <= 1'b0;
            end else begin
                pend_q <= 1'b1;
            end
        end
    end

    // Select filtered or raw level.
    assign out = enable ? filt_q : raw;
endmodule

// File: rtl/pin_debounce_filter.sv
// Module: top of the prescaled per-pin debouncer. One shared divider
// feeds NP per-line filters; the select register picks filtered lines.
module pin_debounce_filter
    import dbf_pkg::*;
#(
    parameter int NP = NPIN,
    parameter int DW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NP-1:0]     pin_raw,
    output logic [NP-1:0]     pin_out
);
    logic [NP-1:0] sel_q;
    logic [DW-1:0] div_q;
    logic          div_restart;
    logic          tick;

    dbf_regs #(.NP(NP), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_q(sel_q), .div_q(div_q), .div_restart(div_restart)
    );

    dbf_prescaler #(.DW(DW)) u_pre (
        .clk(clk), .rst_n(rst_n), .div(div_q), .restart(div_restart),
        .tick(tick)
    );

    for (genvar i = 0; i < NP; i++) begin : g_pin
        dbf_pin_filter u_flt (
            .clk(clk), .rst_n(rst_n), .tick(tick), .enable(sel_q[i]),
            .raw(pin_raw[i]), .out(pin_out[i])
        );
    end
endmodule

// File: rtl/dbf_checker.sv
// Module: assertion checker bound to pin_debounce_filter.
module dbf_checker
    import dbf_pkg::*;
#(
    parameter int NP = NPIN,
    parameter int DW = DIV_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NP-1:0]     pin_raw,
    input logic [NP-1:0]     pin_out,
    input logic [NP-1:0]     sel_q,
    input logic [DW-1:0]     div_q,
    input logic              tick
);
    logic sel_wr_c;
    logic div_wr_c;
    assign sel_wr_c = bus_sel && bus_wr && (bus_addr == OFF_SELECT);
    assign div_wr_c = bus_sel && bus_wr && (bus_addr == OFF_DIVIDER);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (sel_q == '0 && div_q == '0)); // R1

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFF_DIVIDER) |-> (bus_rdata[DATA_W-1:DW] == '0)); // R3

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ pin_raw) & ~sel_q) == '0)); // R5

    AST_CHANGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sel_wr_c && !div_wr_c) |=> ((pin_out & sel_q) == ($past(pin_out) & sel_q))); // R6

    AST_NO_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> !tick); // R7

    AST_DIVIDER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr_c && bus_wdata[DW-1:0] > DW'(1)) |=> !tick); // R8
endmodule

bind pin_debounce_filter dbf_checker #(.NP(NP), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_raw(pin_raw), .pin_out(pin_out), .sel_q(sel_q), .div_q(div_q),
    .tick(tick)
);

// File: tb/pin_debounce_filter_bench.sv
// Bench: near-exhaustive sweeps of divisor, pin mask and timing offset.
module pin_debounce_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_SEL = 8'h40;
    localparam logic [7:0] A_DIV = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_raw = '0;
    logic [31:0] pin_out;

    int n_checks = 0;
    int n_fail = 0;

    pin_debounce_filter u_pin_debounce_filter (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_raw(pin_raw), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic reg_wr_raw(input logic [7:0] a, input logic [31:0] d, input logic [31:0] r);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pin_raw = r;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr_raw(a, d, pin_raw);
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Park divider, clear filters to raw 0, then select mask m.
    task automatic setup(input logic [31:0] m);
        reg_wr(A_DIV, 32'h0);
        reg_wr(A_SEL, 32'h0);
        pin_raw = '0;
        idle(2);
        reg_wr(A_SEL, m);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] pat;
        logic [31:0] m;
        logic [31:0] held;
        logic        bad;

        // R1: reset state
        pin_raw = 32'h5A5A_00FF;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        reg_rd(A_SEL, d); check("R1 select after reset", d, 32'h0);
        reg_rd(A_DIV, d); check("R1 divider after reset", d, 32'h0);
        check("R1 output equals raw", pin_out, 32'h5A5A_00FF);

        // R2, R3: register readback
        for (int i = 0; i < 4; i++) begin
            pat = 32'hC3A5_0F1E ^ (32'h1111_1111 * i);
            reg_wr(A_SEL, pat); reg_rd(A_SEL, d); check("R2 select readback", d, pat);
            reg_wr(A_DIV, pat); reg_rd(A_DIV, d); check("R3 divider readback", d, pat & 32'h00FF_FFFF);
        end
        reg_wr(A_DIV, 32'hFFFF_FFFF); reg_rd(A_DIV, d); check("R3 upper bits zero", d, 32'h00FF_FFFF);

        // R9: unmapped offsets
        reg_wr(A_SEL, 32'h1234_5678); reg_wr(A_DIV, 32'h0000_0ABC);
        for (int a = 0; a < 8; a++) begin
            reg_wr(8'h48 + 8'(a * 4), 32'hFFFF_FFFF);
            reg_rd(8'h48 + 8'(a * 4), d); check("R9 unmapped read zero", d, 32'h0);
        end
        reg_rd(A_SEL, d); check("R9 select untouched", d, 32'h1234_5678);
        reg_rd(A_DIV, d); check("R9 divider untouched", d, 32'h0000_0ABC);

        // R4: latency sweep over divisors and masks
        for (int p = 1; p <= 6; p++) begin
            for (int k = 0; k < 3; k++) begin
                m   = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0F0F_F0F0 : 32'h8000_0001;
                pat = 32'hFFFF_FFFF ^ (32'h0001_0000 * p);
                setup(m);
                reg_wr_raw(A_DIV, 32'(p), pat);
                check("R4 edge 0 only unfiltered lines", pin_out, pat & ~m);
                idle(2 * p - 1);
                check("R4 before edge 2P", pin_out, pat & ~m);
                idle(1);
                check("R4 at edge 2P", pin_out, pat);
            end
        end
        setup(32'hFFFF_FFFF);
        reg_wr_raw(A_DIV, 32'd300, 32'h00FF_FF00);
        idle(599); check("R4 divisor 300 before", pin_out, 32'h0);
        idle(1);   check("R4 divisor 300 at edge", pin_out, 32'h00FF_FF00);

        // R6: single-tick pulses are rejected
        for (int p = 1; p <= 5; p++) begin
            setup(32'hFFFF_FFFF);
            reg_wr_raw(A_DIV, 32'(p), 32'hFFFF_FFFF);
            bad = 1'b0;
            idle(p);
            pin_raw = '0;
            idle(2 * p);
            pin_raw = 32'hFFFF_FFFF;
            if (pin_out != 0) bad = 1'b1;
            idle(p);
            pin_raw = '0;
            for (int c = 0; c < 3 * p + 2; c++) begin
                if (pin_out != 0) bad = 1'b1;
                @(negedge clk);
            end
            check("R6 glitch rejected", {31'b0, bad}, 32'h0);
        end

        // R8: rewrite restarts the count
        for (int p = 4; p <= 6; p++) begin
            for (int k = 1; k <= p - 2; k++) begin
                setup(32'hFFFF_FFFF);
                reg_wr(A_DIV, 32'(p));
                idle(k);
                reg_wr_raw(A_DIV, 32'(p), 32'hAAAA_5555);
                idle(2 * p - 1);
                check("R8 restart before edge 2P", pin_out, 32'h0);
                idle(1);
                check("R8 restart at edge 2P", pin_out, 32'hAAAA_5555);
            end
        end

        // R7: divisor 0 freezes filtered lines
        setup(32'hFFFF_FFFF);
        reg_wr_raw(A_DIV, 32'd1, 32'hFFFF_FFFF);
        idle(2);
        check("R7 precondition all high", pin_out, 32'hFFFF_FFFF);
        reg_wr(A_DIV, 32'h0);
        pin_raw = 32'h0;
        idle(40);
        check("R7 held with divisor zero", pin_out, 32'hFFFF_FFFF);

        // R5: unselected lines follow raw in the same cycle
        reg_wr(A_SEL, 32'h0000_FFFF);
        held = pin_out & 32'h0000_FFFF;
        for (int i = 0; i < 16; i++) begin
            pat = 32'h9E37_79B9 * (i + 1);
            pin_raw = pat;
            #1 check("R5 pass-through", pin_out, (pat & 32'hFFFF_0000) | held);
            @(negedge clk);
        end

        // R10: enabling shows the current raw level at once
        reg_wr(A_SEL, 32'h0);
        pin_raw = 32'h3C3C_A5A5;
        idle(2);
        reg_wr(A_SEL, 32'hFFFF_FFFF);
        check("R10 enable shows raw", pin_out, 32'h3C3C_A5A5);
        pin_raw = 32'h0;
        idle(20);
        check("R10 then held", pin_out, 32'h3C3C_A5A5);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule